// File: doc/BRIEF.md
# Strobe Delay Window Calibration Engine

This block tunes the delay applied to a memory data strobe. It steps a candidate index upward and, for each candidate, drives the Gray-coded form of that index onto the delay control output. It then runs a short write-and-readback trial through a request/response memory port. The trial checks whether memory traffic survives at that setting. The first index that works marks the lower edge of the working window. A second scan then looks for the first index that fails, which marks the upper edge. The engine settles on a point two thirds of the way into the window and drives its Gray code as the final setting.

A single-cycle start request begins a calibration. When the engine applies its final setting, it raises a one-cycle completion pulse and holds the lower edge, upper edge and chosen index on its outputs. If no candidate ever passes, it applies a fixed fallback setting and raises a failure flag. When the memory holds two ranks, a rank offset input spreads half of each trial's words into the second rank. With one rank, that input is tied to zero.

Top module: `strobe_delay_cal`

## Requirements
- R1: After reset, `done_o`, `fail_o` and `mem_req_o` are 0, and `delay_o`, `low_o`, `high_o` and `final_o` are 0.
- R2: Candidate indices run from 0 to 254. While candidate i is under trial, `delay_o` equals i XOR (i>>1). During a scan, successive settings differ in exactly one bit.
- R3: A trial makes eighteen accesses in this order: six writes of zero, then six writes of the pattern words, then six reads. For word k (0..5), the pattern is, in order, 0x12345678, 0x81234567, 0x78123456, 0x67812345, 0x56781234, 0x45678123. Word k sits at block + k*0x100, and odd k also adds `rank_off_i`.
- R4: A trial stops at its first read whose data differs from the expected pattern and issues none of its remaining reads. Such a trial fails.
- R5: The lower-edge scan uses block 0x4000, starts at index 0 and stops at the first passing index. That index is reported on `low_o`.
- R6: The upper-edge scan uses block 0x8000 and starts at `low_o`+1. `high_o` is the first failing index in that scan, or 255 if every index up to 254 passes (including the case where the lower edge is 254).
- R7: `final_o` = low + (2*(high-low))/3 with integer division, and `delay_o` then holds the Gray code of `final_o`.
- R8: If no index from 0 to 254 passes, `delay_o` becomes 0x59, `fail_o` becomes 1, and `low_o`, `high_o` and `final_o` all read 255.
- R9: `done_o` is high for exactly one cycle, in the cycle the final setting appears on `delay_o`. A start request made while a calibration is running is ignored.
- R10: A memory request holds its address, direction and write data unchanged until the cycle in which `mem_ack_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin calibration |
| rank_off_i | input | ADDR_W | Base address of second rank, 0 for one rank |
| delay_o | output | IDX_W | Gray-coded delay setting |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| low_o | output | IDX_W | Lower window edge |
| high_o | output | IDX_W | Upper window edge |
| final_o | output | IDX_W | Chosen index (not Gray-coded) |
| fail_o | output | 1 | No candidate passed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 32-bit addresses and the 0x4000/0x8000 blocks. This gives a full sweep of all 255 candidates in a few thousand cycles per calibration. The memory model corrupts reads outside a chosen pass window. Sweeping windows at index 0, at 254, one candidate wide, wide open and empty reaches every edge-scan termination path. Nonzero rank offsets exercise the odd-word address split, and a start pulse in mid-run covers the ignore rule.

// File: rtl/strobe_cal_pkg.sv
// Shared types and constants for the strobe delay calibration engine.
// Assumes 32-bit trial words and a fixed six-word trial.
package strobe_cal_pkg;

    localparam int DATA_W    = 32;
    localparam int WORDS     = 6;
    localparam int WORD_IDXW = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_CLEAR, PH_WRITE, PH_READ} phase_t;
    typedef enum logic [1:0] {SW_IDLE, SW_LOW, SW_HIGH} sweep_t;

    // Pattern written to trial word k.
    function automatic logic [DATA_W-1:0] trial_pattern(input logic [WORD_IDXW-1:0] k);
        case (k)
            3'd0:    trial_pattern = 32'h12345678;
            3'd1:    trial_pattern = 32'h81234567;
            3'd2:    trial_pattern = 32'h78123456;
            3'd3:    trial_pattern = 32'h67812345;
            3'd4:    trial_pattern = 32'h56781234;
            default: trial_pattern = 32'h45678123;
        endcase
    endfunction

endpackage

// File: rtl/strobe_cal_addr.sv
// Address generator: maps block select and word number to a memory address.
// Assumes odd words go to the second rank via an additive offset.
module strobe_cal_addr #(
    parameter int          ADDR_W    = 32,
    parameter int unsigned LOW_BASE  = 'h4000,
    parameter int unsigned HIGH_BASE = 'h8000,
    parameter int unsigned STRIDE    = 'h100
) (
    input  logic                                  high_blk_i,
    input  logic [strobe_cal_pkg::WORD_IDXW-1:0]  word_i,
    input  logic [ADDR_W-1:0]                     rank_off_i,
    output logic [ADDR_W-1:0]                     addr_o
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] step;

    // Form block base, word step and optional rank offset.
    always_comb begin
        base   = high_blk_i ? ADDR_W'(HIGH_BASE) : ADDR_W'(LOW_BASE);
        step   = ADDR_W'(word_i) * ADDR_W'(STRIDE);
        addr_o = base + step + (word_i[0] ? rank_off_i : '0);
    end

endmodule

// File: rtl/strobe_cal_trial.sv
// Trial sequencer: clears six words, writes six patterns, reads them back.
// Assumes the memory holds a request until acknowledged; aborts on first bad read.
module strobe_cal_trial #(
    parameter int          ADDR_W    = 32,
    parameter int unsigned LOW_BASE  = 'h4000,
    parameter int unsigned HIGH_BASE = 'h8000,
    parameter int unsigned STRIDE    = 'h100
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic                               high_blk_i,
    input  logic [ADDR_W-1:0]                  rank_off_i,
    output logic                               mem_req_o,
    output logic                               mem_we_o,
    output logic [ADDR_W-1:0]                  mem_addr_o,
    output logic [strobe_cal_pkg::DATA_W-1:0]  mem_wdata_o,
    input  logic                               mem_ack_i,
    input  logic [strobe_cal_pkg::DATA_W-1:0]  mem_rdata_i,
    output logic                               done_o,
    output logic                               pass_o
);
    import strobe_cal_pkg::*;

    localparam logic [WORD_IDXW-1:0] LAST_WORD = WORD_IDXW'(WORDS - 1);

    phase_t                 ph;
    logic [WORD_IDXW-1:0]   word;
    logic                   blk_q;
    logic [DATA_W-1:0]      expect_w;
    logic                   mismatch;

    strobe_cal_addr #(
        .ADDR_W   (ADDR_W),
        .LOW_BASE (LOW_BASE),
        .HIGH_BASE(HIGH_BASE),
        .STRIDE   (STRIDE)
    ) u_addr (
        .high_blk_i(blk_q),
        .word_i    (word),
        .rank_off_i(rank_off_i),
        .addr_o    (mem_addr_o)
    );

    // Drive the memory port from the current phase and word.
    always_comb begin
        expect_w    = trial_pattern(word);
        mem_req_o   = (ph != PH_IDLE);
        mem_we_o    = (ph != PH_READ);
        mem_wdata_o = (ph == PH_CLEAR) ? '0 : expect_w;
        mismatch    = (mem_rdata_i != expect_w);
    end

    // Step through clear, write and read phases; report the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            word   <= '0;
            blk_q  <= 1'b0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start_i) begin
                        ph    <= PH_CLEAR;
                        word  <= '0;
                        blk_q <= high_blk_i;
                    end
                end
                PH_CLEAR, PH_WRITE: begin
                    if (mem_ack_i) begin
                        if (word == LAST_WORD) begin
                            word <= '0;
                            ph   <= (ph == PH_CLEAR) ? PH_WRITE : PH_READ;
                        end else begin
                            word <= word + 1'b1;
                        end
                    end
                end
                PH_READ: begin
                    if (mem_ack_i) begin
                        if (mismatch) begin
                            ph     <= PH_IDLE;
                            done_o <= 1'b1;
                            pass_o <= 1'b0;
                        end else if (word == LAST_WORD) begin
                            ph     <= PH_IDLE;
                            done_o <= 1'b1;
                            pass_o <= 1'b1;
                        end else begin
                            word <= word + 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R10

    AST_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_READ && mem_ack_i && mem_rdata_i != trial_pattern(word)) |=> !mem_req_o); // R4

    AST_TRIAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R3

endmodule

// File: rtl/strobe_cal_sweep.sv
// Sweep controller: runs the first-pass and first-fail scans over candidate
// indices, then applies a point two thirds into the window or a fallback.
// Assumes the trial sequencer accepts a start one cycle after reporting.
module strobe_cal_sweep #(
    parameter int IDX_W           = 8,
    parameter int DEFAULT_SETTING = 'h59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             trial_done_i,
    input  logic             trial_pass_i,
    output logic             trial_start_o,
    output logic             high_blk_o,
    output logic [IDX_W-1:0] delay_o,
    output logic [IDX_W-1:0] low_o,
    output logic [IDX_W-1:0] high_o,
    output logic [IDX_W-1:0] final_o,
    output logic             fail_o,
    output logic             done_o
);
    import strobe_cal_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX  = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LAST_CAND = LAST_IDX - 1'b1;
    localparam logic [IDX_W-1:0] FALLBACK  = IDX_W'(DEFAULT_SETTING);

    sweep_t           st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nxt;
    logic [IDX_W-1:0] nxt_gray;
    logic [IDX_W-1:0] lo_sel;
    logic [IDX_W-1:0] hi_sel;
    logic [IDX_W-1:0] span;
    logic [IDX_W:0]   twice;
    logic [IDX_W-1:0] fin;
    logic [IDX_W-1:0] fin_gray;

    // Next candidate and the two-thirds point of the window being closed.
    always_comb begin
        nxt      = idx + 1'b1;
        nxt_gray = nxt ^ (nxt >> 1);
        lo_sel   = (st == SW_LOW) ? idx : low_o;
        hi_sel   = (st == SW_HIGH && !trial_pass_i) ? idx : LAST_IDX;
        span     = hi_sel - lo_sel;
        twice    = {span, 1'b0};
        fin      = lo_sel + IDX_W'(twice / 3);
        fin_gray = fin ^ (fin >> 1);
    end

    // Scan state machine: start, advance candidates, close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= SW_IDLE;
            idx           <= '0;
            delay_o       <= '0;
            low_o         <= '0;
            high_o        <= '0;
            final_o       <= '0;
            fail_o        <= 1'b0;
            done_o        <= 1'b0;
            trial_start_o <= 1'b0;
            high_blk_o    <= 1'b0;
        end else begin
            done_o        <= 1'b0;
            trial_start_o <= 1'b0;
            case (st)
                SW_IDLE: begin
                    if (start_i) begin
                        st            <= SW_LOW;
                        idx           <= '0;
                        delay_o       <= '0;
                        low_o         <= '0;
                        high_o        <= '0;
                        final_o       <= '0;
                        fail_o        <= 1'b0;
                        high_blk_o    <= 1'b0;
                        trial_start_o <= 1'b1;
                    end
                end
                SW_LOW: begin
                    if (trial_done_i) begin
                        if (trial_pass_i) begin
                            low_o <= idx;
                            if (idx == LAST_CAND) begin
                                high_o  <= hi_sel;
                                final_o <= fin;
                                delay_o <= fin_gray;
                                done_o  <= 1'b1;
                                st      <= SW_IDLE;
                            end else begin
                                idx           <= nxt;
                                delay_o       <= nxt_gray;
                                high_blk_o    <= 1'b1;
                                trial_start_o <= 1'b1;
                                st            <= SW_HIGH;
                            end
                        end else if (idx == LAST_CAND) begin
                            delay_o <= FALLBACK;
                            fail_o  <= 1'b1;
                            low_o   <= LAST_IDX;
                            high_o  <= LAST_IDX;
                            final_o <= LAST_IDX;
                            done_o  <= 1'b1;
                            st      <= SW_IDLE;
                        end else begin
                            idx           <= nxt;
                            delay_o       <= nxt_gray;
                            trial_start_o <= 1'b1;
                        end
                    end
                end
                SW_HIGH: begin
                    if (trial_done_i) begin
                        if (!trial_pass_i || idx == LAST_CAND) begin
                            high_o  <= hi_sel;
                            final_o <= fin;
                            delay_o <= fin_gray;
                            done_o  <= 1'b1;
                            st      <= SW_IDLE;
                        end else begin
                            idx           <= nxt;
                            delay_o       <= nxt_gray;
                            trial_start_o <= 1'b1;
                        end
                    end
                end
                default: st <= SW_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st != SW_IDLE && $past(st) != SW_IDLE && delay_o != $past(delay_o))
        |-> $countones(delay_o ^ $past(delay_o)) == 1); // R2

    AST_FINAL_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> (final_o >= low_o && final_o < high_o)); // R7

    AST_FAIL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (delay_o == FALLBACK && low_o == LAST_IDX)); // R8

endmodule

// File: rtl/strobe_delay_cal.sv
// Top of the strobe delay calibration engine: sweep controller plus trial
// sequencer. Assumes an external memory that answers each request with ack.
module strobe_delay_cal #(
    parameter int          ADDR_W          = 32,
    parameter int          IDX_W           = 8,
    parameter int unsigned LOW_BASE        = 'h4000,
    parameter int unsigned HIGH_BASE       = 'h8000,
    parameter int unsigned STRIDE          = 'h100,
    parameter int          DEFAULT_SETTING = 'h59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] rank_off_i,
    output logic [IDX_W-1:0]  delay_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic [IDX_W-1:0]  low_o,
    output logic [IDX_W-1:0]  high_o,
    output logic [IDX_W-1:0]  final_o,
    output logic              fail_o,
    output logic              done_o
);
    logic trial_start;
    logic high_blk;
    logic trial_done;
    logic trial_pass;

    strobe_cal_sweep #(
        .IDX_W          (IDX_W),
        .DEFAULT_SETTING(DEFAULT_SETTING)
    ) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .trial_done_i (trial_done),
        .trial_pass_i (trial_pass),
        .trial_start_o(trial_start),
        .high_blk_o   (high_blk),
        .delay_o      (delay_o),
        .low_o        (low_o),
        .high_o       (high_o),
        .final_o      (final_o),
        .fail_o       (fail_o),
        .done_o       (done_o)
    );

    strobe_cal_trial #(
        .ADDR_W   (ADDR_W),
        .LOW_BASE (LOW_BASE),
        .HIGH_BASE(HIGH_BASE),
        .STRIDE   (STRIDE)
    ) u_trial (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (trial_start),
        .high_blk_i (high_blk),
        .rank_off_i (rank_off_i),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o),
        .mem_ack_i  (mem_ack_i),
        .mem_rdata_i(mem_rdata_i),
        .done_o     (trial_done),
        .pass_o     (trial_pass)
    );

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R9

endmodule

// File: tb/strobe_delay_cal_bench.sv
module strobe_delay_cal_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] rank_off = '0;
    logic [7:0]  delay;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [7:0]  low, high, fin;
    logic        fail, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    int win_lo, win_hi, exp_low;
    bit fail_run;
    int reads, addr_err, done_cnt;
    logic [31:0] mem [logic [31:0]];

    always #5 clk = ~clk;

    strobe_delay_cal u_strobe_delay_cal (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rank_off_i(rank_off),
        .delay_o(delay), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .low_o(low), .high_o(high), .final_o(fin),
        .fail_o(fail), .done_o(done)
    );

    function automatic logic [31:0] pat(input int k);
        case (k)
            0: pat = 32'h12345678;
            1: pat = 32'h81234567;
            2: pat = 32'h78123456;
            3: pat = 32'h67812345;
            4: pat = 32'h56781234;
            default: pat = 32'h45678123;
        endcase
    endfunction

    function automatic int gray2bin(input logic [7:0] g);
        logic [7:0] b;
        b[7] = g[7];
        for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return int'(b);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: one-cycle acknowledge, reads corrupted outside the window.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            int cur;
            bit found;
            logic [31:0] blk, d;
            cur = gray2bin(delay);
            blk = (fail_run || cur <= exp_low) ? 32'h4000 : 32'h8000;
            found = 0;
            for (int k = 0; k < 6; k++) begin
                if (mem_addr == blk + 32'(k) * 32'h100 + ((k % 2 == 1) ? rank_off : 32'h0)) begin
                    found = 1;
                    if (mem_we && mem_wdata != 32'h0 && mem_wdata != pat(k)) addr_err++;
                end
            end
            if (!found) addr_err++;
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
            end else begin
                reads++;
                d = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                mem_rdata <= (cur >= win_lo && cur <= win_hi) ? d : (d ^ 32'h1);
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) if (rst_n && done) done_cnt++;

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_up();
        end
    end

    task automatic run_case(input int lo, input int hi, input logic [31:0] off, input bit mid_start);
        int e_low, e_high, e_fin, e_reads, last, e_delay;
        win_lo = lo; win_hi = hi; rank_off = off;
        if (lo <= 254 && lo <= hi) begin
            fail_run = 0;
            e_low  = lo;
            e_high = (hi >= 254) ? 255 : hi + 1;
            e_fin  = e_low + (2 * (e_high - e_low)) / 3;
            e_delay = e_fin ^ (e_fin >> 1);
            last = (e_high > 254) ? 254 : e_high;
        end else begin
            fail_run = 1;
            e_low = 255; e_high = 255; e_fin = 255; e_delay = 'h59; last = 254;
        end
        exp_low = e_low;
        e_reads = 0;
        for (int i = 0; i <= last; i++) e_reads += (i >= lo && i <= hi) ? 6 : 1;
        reads = 0; addr_err = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        do begin
            @(posedge clk); #1;
        end while (!done);
        check(low == 8'(e_low),   "R5 low bound",  low,  e_low);
        check(high == 8'(e_high), "R6 high bound", high, e_high);
        check(fin == 8'(e_fin),   "R7 final index", fin, e_fin);
        check(delay == 8'(e_delay), fail_run ? "R8 fallback delay" : "R7 gray final delay", delay, e_delay);
        check(fail == fail_run,   "R8 fail flag",  fail, fail_run);
        check(reads == e_reads,   "R4 read count with abort", reads, e_reads);
        check(addr_err == 0,      "R3 address and data order", addr_err, 0);
        @(posedge clk); #1;
        check(!done, "R9 done single cycle", done, 0);
        check(done_cnt == 1, mid_start ? "R9 start ignored while busy" : "R9 done count", done_cnt, 1);
        check(delay == 8'(e_delay), "R2 delay held after done", delay, e_delay);
    endtask

    initial begin
        win_lo = 0; win_hi = 0; exp_low = 0; fail_run = 0;
        reads = 0; addr_err = 0; done_cnt = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!done && !fail && !mem_req, "R1 reset control outputs", {done, fail, mem_req}, 0);
        check(delay == 0 && low == 0 && high == 0 && fin == 0, "R1 reset values",
              {delay, low, high, fin}, 0);
        rst_n = 1'b1;
        run_case(10, 40, 32'h0, 0);
        run_case(0, 254, 32'h0100_0000, 0);
        run_case(255, 255, 32'h0, 0);
        run_case(254, 254, 32'h0, 0);
        run_case(100, 100, 32'h0200_0000, 1);
        run_case(0, 0, 32'h0, 0);
        run_case(3, 200, 32'h0040_0000, 0);
        finish_up();
    end

endmodule